// File: doc/BRIEF.md
# Carry-Skip Block Adder

This block adds two unsigned operands and an incoming carry, splitting the operand width into equal groups of bits. Each group forms per-bit propagate and generate terms, ripples its own carry chain from bit to bit, and owns a bypass multiplexer on its carry-out.

When every bit of a group propagates, the carry entering that group is forwarded straight to the group's carry-out. Otherwise the group's own ripple carry is used. A carry can therefore jump over whole groups of propagating bits.

The sum bits of each group always come from the group's local carries, which settle once the true carry into the group is known. Sum and carry-out are captured in output registers with a synchronous active-high reset, so a result appears one clock after its operands. The default build is 16 bits as four groups of four.

Top module: `cskip_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_q` and `c_out_q` are cleared to zero at that edge.
- R2: With `rst` low, the pair {`c_out_q`, `sum_q`} after a rising edge equals `a_in + b_in + c_in` sampled at that edge, so results have one cycle of latency.
- R3: The operand is divided into NUM_GRP groups of GRP_W bits. Group k covers bits k*GRP_W to k*GRP_W+GRP_W-1, and group 0 takes `c_in`. A carry crossing every group boundary gives the correct sum.
- R4: Per bit, propagate is a XOR b and generate is a AND b. The sum bit is propagate XOR the carry into that bit.
- R5: When all propagate bits of a group are 1, the group carry-out equals the group carry-in. For example, with a = ~b, the sum is all ones and carry-out is 0 when `c_in` = 0, and the sum is zero and carry-out is 1 when `c_in` = 1.
- R6: When any bit of a group generates or kills, that group's carry-out does not depend on its carry-in and equals the carry of the group's operands added with no carry-in.
- R7: `c_out_q` is the carry leaving the most significant group, that is, bit WIDTH of the full sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH (16) | First operand |
| b_in | input | WIDTH (16) | Second operand |
| c_in | input | 1 | Carry into the lowest group |
| sum_q | output | WIDTH (16) | Registered sum |
| c_out_q | output | 1 | Registered carry-out of the top group |

## Verification
The sum and the carry-out are both due exactly one rising edge after the operands are applied. The bench drives operands on a falling edge and compares both outputs on the next falling edge, after exactly one capturing edge. Directed cases force every group into skip mode, force a carry across each group boundary, and make the top group generate under both carry-in values. Seeded random operands fill in the remainder, each compared against a bench-computed addition.

// File: rtl/cskip_pkg.sv
package cskip_pkg;
  parameter int unsigned DEF_GRP_W   = 4;
  parameter int unsigned DEF_NUM_GRP = 4;
endpackage

// File: rtl/cskip_pg_bits.sv
module cskip_pg_bits #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prop,
  output logic [W-1:0] gen
);
  // R4: per-bit propagate and generate terms
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign prop[i] = a[i] ^ b[i];
    assign gen[i]  = a[i] & b[i];
  end
endmodule

// File: rtl/cskip_group.sv
module cskip_group #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output logic          cout
);
  logic [GW-1:0] prop, gen;
  logic [GW:0]   chain;
  logic          skip;

  cskip_pg_bits #(.W(GW)) i_pg (
    .a(a), .b(b), .prop(prop), .gen(gen)
  );

  assign chain[0] = cin;
  for (genvar i = 0; i < GW; i++) begin : g_ripple
    assign chain[i+1] = gen[i] | (prop[i] & chain[i]);
    assign sum[i]     = prop[i] ^ chain[i];   // R4
  end

  assign skip = &prop;
  assign cout = skip ? cin : chain[GW];      // R5 / R6 bypass mux

  logic [GW:0] no_cin_sum;
  assign no_cin_sum = {1'b0, a} + {1'b0, b};

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      // R5: a fully propagating group passes its carry-in through
      a_r5_skip_pass: assert (!skip || (cout == cin));
      // R6: otherwise the carry-out is fixed by the operands alone
      a_r6_local_carry: assert (skip || (cout == no_cin_sum[GW]));
    end
  end
endmodule

// File: rtl/cskip_adder.sv
module cskip_adder
  import cskip_pkg::*;
#(
  parameter int unsigned GRP_W   = DEF_GRP_W,
  parameter int unsigned NUM_GRP = DEF_NUM_GRP,
  localparam int unsigned WIDTH  = GRP_W * NUM_GRP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum_q,
  output logic             c_out_q
);
  logic [NUM_GRP:0] grp_c;
  logic [WIDTH-1:0] sum_d;

  assign grp_c[0] = c_in;   // R3: group 0 takes the adder carry-in

  for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
    cskip_group #(.GW(GRP_W)) i_grp (
      .a   (a_in[k*GRP_W +: GRP_W]),
      .b   (b_in[k*GRP_W +: GRP_W]),
      .cin (grp_c[k]),
      .sum (sum_d[k*GRP_W +: GRP_W]),
      .cout(grp_c[k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      c_out_q <= 1'b0;
    end else begin
      sum_q   <= sum_d;
      c_out_q <= grp_c[NUM_GRP];   // R7
    end
  end

  // Checks on the registered result
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && c_out_q == 1'b0));

  a_r2_sum_latency: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ({c_out_q, sum_q} ==
      ({1'b0, $past(a_in)} + {1'b0, $past(b_in)} + {{WIDTH{1'b0}}, $past(c_in)})));

  a_r7_full_skip_cout: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past((a_in ^ b_in) == {WIDTH{1'b1}})) |-> (c_out_q == $past(c_in)));
endmodule

// File: tb/test_cskip_adder.sv
module test_cskip_adder;
  localparam int unsigned GW = 4;
  localparam int unsigned NG = 4;
  localparam int unsigned W  = GW * NG;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         c_in = 1'b0;
  logic [W-1:0] sum_q;
  logic         c_out_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cskip_adder #(.GRP_W(GW), .NUM_GRP(NG)) i_cskip_adder (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .sum_q(sum_q), .c_out_q(c_out_q)
  );

  function automatic logic [W:0] ref_add(logic [W-1:0] a, logic [W-1:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  task automatic compare(string req, logic [W:0] got, logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive on a falling edge, check on the next falling edge (one capture edge)
  task automatic apply(string req, logic [W-1:0] a, logic [W-1:0] b, logic c);
    @(negedge clk);
    a_in = a; b_in = b; c_in = c;
    @(negedge clk);
    compare(req, {c_out_q, sum_q}, ref_add(a, b, c));
  endtask

  initial begin
    void'($urandom(32'd1234));
    a_in = 16'hA5C3; b_in = 16'h7E19; c_in = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 reset clear", {c_out_q, sum_q}, '0);
    rst = 1'b0;

    apply("R5 all groups skip, cin=1", 16'h5A3C, ~16'h5A3C, 1'b1);
    compare("R5 expected zero sum carry one", {c_out_q, sum_q}, {1'b1, 16'h0000});
    apply("R5 all groups skip, cin=0", 16'h1234, ~16'h1234, 1'b0);
    compare("R5 expected ones sum carry zero", {c_out_q, sum_q}, {1'b0, 16'hFFFF});
    apply("R3 ripple across every group", 16'hFFFF, 16'h0000, 1'b1);
    apply("R3 carry into top group", 16'h0FFF, 16'h0001, 1'b0);
    apply("R3 carry into group 1", 16'h000F, 16'h0001, 1'b0);
    apply("R3 carry into group 2", 16'h00FF, 16'h0000, 1'b1);
    apply("R6 top group generates, cin=0", 16'h8000, 16'h8000, 1'b0);
    apply("R6 top group generates, cin=1", 16'h8000, 16'h8000, 1'b1);
    apply("R6 kill in each group", 16'h4444, 16'h3333, 1'b1);
    apply("R4 zero operands", 16'h0000, 16'h0000, 1'b0);
    apply("R7 max plus max", 16'hFFFF, 16'hFFFF, 1'b1);

    for (int n = 0; n < 300; n++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = (n % 3 == 0) ? (~ra ^ W'(1 << ($urandom % W))) : W'($urandom);
      apply("R2 random", ra, rb, 1'($urandom));
    end

    @(negedge clk);
    rst = 1'b1;
    a_in = 16'hFFFF; b_in = 16'h0001;
    @(negedge clk);
    compare("R1 reset mid-run", {c_out_q, sum_q}, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule